// File: doc/BRIEF.md
# Shift and Rotate Unit with Carry

This unit performs barrel shifts and rotates on a 32-bit or a 64-bit operand. It supports logical left shift, logical right shift, arithmetic right shift, plain rotate left and right, and rotate left and right through the carry bit. Each request arrives with an operation code, a width select, the source operand, a shift amount and an incoming carry. One clock edge later the unit presents the result with three flags: carry (C), zero (Z) and sign (S).

The carry output always holds the last bit that left the operand. For a plain rotate this is the bit that wrapped around to the other end. In the through-carry forms, the operand and the carry bit form one ring of width+1 bits. The incoming carry fills the vacated end, and the bit that leaves becomes the new carry. Software uses this to chain a 128-bit rotate across two 64-bit registers. Only the low bits of the shift amount are used: 5 bits in 32-bit mode and 6 bits in 64-bit mode.

Top module: `shift_rotate_unit`

## Requirements
- R1: The effective count is `amount[4:0]` when `wide`=0 and `amount[5:0]` when `wide`=1. All higher amount bits are ignored.
- R2: Operation code 0 (shift left) fills the vacated bits with zeros. C is the last bit shifted out of the top, which is source bit W-n.
- R3: Operation code 1 (logical right) fills with zeros, and code 2 (arithmetic right) fills with copies of the sign bit. For both, C is source bit n-1. An arithmetic shift by W-1 gives a result made only of sign-bit copies.
- R4: Operation code 3 rotates left, and C equals the new bit 0. Operation code 4 rotates right, and C equals the new bit W-1.
- R5: Operation code 5 rotates left and code 6 rotates right through a (W+1)-bit ring made of carry and operand. `carry_in` enters at the vacated end, and C is the last bit rotated out. Two chained 64-bit steps form a 128-bit rotate.
- R6: When the effective count is zero, the result equals the source and C equals `carry_in`, for every operation.
- R7: Z is 1 exactly when the W-bit result is zero. S equals result bit W-1.
- R8: In 32-bit mode, source bits 63:32 are ignored and result bits 63:32 are zero.
- R9: Results and flags appear one cycle after `in_valid`, with `out_valid` high for that cycle only. They hold while no request arrives. Reset clears every output to zero.
- R10: Operation code 7 passes the source through unchanged, and C equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R2 to R5, R10) |
| wide | input | 1 | 1 selects 64-bit, 0 selects 32-bit |
| src | input | 64 | Source operand |
| amount | input | 8 | Shift or rotate amount |
| carry_in | input | 1 | Incoming carry |
| out_valid | output | 1 | Result valid |
| result | output | 64 | Shifted or rotated value |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |

## Verification
Directed operands place single set bits at each end of the word. This distinguishes the direction of each operation and the source of C. Amounts 32 and 64 (which mask to zero) and 0x41 and 0x21 (which mask to one) separate correct count masking from counts that reach the upper amount bits. Narrow requests carry garbage in the upper source half, and a 128-bit rotate is built from two through-carry steps. Several hundred random requests are then compared, cycle by cycle, against a bit-serial model in the bench.

// File: rtl/srcu_pkg.sv
package srcu_pkg;
  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_ROLC = 3'd5,
    OP_RORC = 3'd6,
    OP_PASS = 3'd7
  } sr_op_e;
endpackage

// File: rtl/srcu_lane.sv
// Combinational shifter/rotator for one operand width W.
module srcu_lane import srcu_pkg::*; #(
  parameter int W = 32
) (
  input  sr_op_e                 op,
  input  logic [W-1:0]           x,
  input  logic [$clog2(W)-1:0]   n,
  input  logic                   cin,
  output logic [W-1:0]           res,
  output logic                   cout
);
  localparam int NW = $clog2(W);
  localparam int BW = NW + 2;

  logic [BW-1:0]       back_w, back_r;
  logic [W:0]          lft, rgt, ring, ring_l, ring_r;
  logic signed [W:0]   sar;
  logic [W-1:0]        rol, ror;

  always_comb begin
    back_w = BW'(W) - BW'(n);
    back_r = BW'(W + 1) - BW'(n);
    // a guard bit beside the operand catches the last bit moved out
    lft    = {1'b0, x} << n;
    rgt    = {x, 1'b0} >> n;
    sar    = $signed({x, 1'b0}) >>> n;
    rol    = (x << n) | (x >> back_w);
    ror    = (x >> n) | (x << back_w);
    // carry joins the operand as bit W of a (W+1)-bit ring
    ring   = {cin, x};
    ring_l = (ring << n) | (ring >> back_r);
    ring_r = (ring >> n) | (ring << back_r);
    res  = x;
    cout = cin;
    case (op)
      OP_SHL:  begin res = lft[W-1:0];    cout = lft[W];     end
      OP_SHR:  begin res = rgt[W:1];      cout = rgt[0];     end
      OP_SAR:  begin res = sar[W:1];      cout = sar[0];     end
      OP_ROL:  begin res = rol;           cout = rol[0];     end
      OP_ROR:  begin res = ror;           cout = ror[W-1];   end
      OP_ROLC: begin res = ring_l[W-1:0]; cout = ring_l[W];  end
      OP_RORC: begin res = ring_r[W-1:0]; cout = ring_r[W];  end
      default: begin res = x;             cout = cin;        end
    endcase
    if (n == '0) begin
      res  = x;
      cout = cin;
    end
  end
endmodule

// File: rtl/srcu_flags.sv
// Zero and sign flags for the selected width.
module srcu_flags #(
  parameter int DW   = 64,
  parameter int NARW = 32
) (
  input  logic          wide,
  input  logic [DW-1:0] res,
  output logic          z,
  output logic          s
);
  always_comb begin
    z = (res == '0);
    s = wide ? res[DW-1] : res[NARW-1];
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit import srcu_pkg::*; #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  parameter int AMT_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] src,
  input  logic [AMT_W-1:0]  amount,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_c,
  output logic              flag_z,
  output logic              flag_s
);
  localparam int LNW = $clog2(DATA_W);
  localparam int LNN = $clog2(NARROW_W);

  sr_op_e            op_e;
  logic [DATA_W-1:0] lane_res [2];
  logic              lane_c   [2];
  logic [DATA_W-1:0] sel_res;
  logic              sel_c, nz, ns;
  logic [LNW-1:0]    n_sel;
  logic [DATA_W-1:0] src_sel;

  assign op_e    = sr_op_e'(op);
  assign n_sel   = wide ? amount[LNW-1:0] : LNW'(amount[LNN-1:0]);
  assign src_sel = wide ? src : DATA_W'(src[NARROW_W-1:0]);

  // lane 0 is the narrow width, lane 1 the full width
  for (genvar g = 0; g < 2; g++) begin : g_lane
    localparam int LW = (g == 0) ? NARROW_W : DATA_W;
    localparam int LN = $clog2(LW);
    logic [LW-1:0] r;
    logic          c;
    srcu_lane #(.W(LW)) u_lane (
      .op(op_e), .x(src[LW-1:0]), .n(amount[LN-1:0]), .cin(carry_in),
      .res(r), .cout(c)
    );
    assign lane_res[g] = DATA_W'(r);
    assign lane_c[g]   = c;
  end

  assign sel_res = wide ? lane_res[1] : lane_res[0];
  assign sel_c   = wide ? lane_c[1]   : lane_c[0];

  srcu_flags #(.DW(DATA_W), .NARW(NARROW_W)) u_flags (
    .wide(wide), .res(sel_res), .z(nz), .s(ns)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flag_c    <= 1'b0;
      flag_z    <= 1'b0;
      flag_s    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= sel_res;
        flag_c <= sel_c;
        flag_z <= nz;
        flag_s <= ns;
      end
    end
  end

  a_r9_valid_latency: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c)));
  a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && n_sel == '0) |=> (result == $past(src_sel) && flag_c == $past(carry_in)));
  a_r3_sar_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_SAR && wide && n_sel == LNW'(DATA_W-1))
      |=> result == {DATA_W{$past(src[DATA_W-1])}});
  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide) |=> result[DATA_W-1:NARROW_W] == '0);
  a_r4_rol_carry_lsb: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_e == OP_ROL && n_sel != '0) |=> flag_c == result[0]);
  a_r7_sign_msb: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> flag_s == ($past(wide) ? result[DATA_W-1] : result[NARROW_W-1]));
endmodule

// File: tb/tb_shift_rotate_unit.sv
module tb_shift_rotate_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        wide = 1'b0;
  logic [63:0] src = '0;
  logic [7:0]  amount = '0;
  logic        carry_in = 1'b0;
  logic        out_valid, flag_c, flag_z, flag_s;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  shift_rotate_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .wide(wide),
    .src(src), .amount(amount), .carry_in(carry_in), .out_valid(out_valid),
    .result(result), .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s)
  );

  // bit-serial reference: one single-bit step per count
  function automatic void model(input logic [2:0] o, input logic w64,
      input logic [63:0] s, input logic [7:0] a, input logic ci,
      output logic [63:0] r, output logic c);
    int w = w64 ? 64 : 32;
    int n = w64 ? int'(a[5:0]) : int'(a[4:0]);
    logic [63:0] x = w64 ? s : {32'd0, s[31:0]};
    logic b;
    c = ci;
    for (int i = 0; i < n; i++) begin
      case (o)
        3'd0: begin c = x[w-1]; x = x << 1; end
        3'd1: begin c = x[0]; x = x >> 1; end
        3'd2: begin b = x[w-1]; c = x[0]; x = x >> 1; x[w-1] = b; end
        3'd3: begin b = x[w-1]; x = x << 1; x[0] = b; c = b; end
        3'd4: begin b = x[0]; x = x >> 1; x[w-1] = b; c = b; end
        3'd5: begin b = x[w-1]; x = x << 1; x[0] = c; c = b; end
        3'd6: begin b = x[0]; x = x >> 1; x[w-1] = c; c = b; end
        default: ;
      endcase
      if (w == 32) x[63:32] = '0;
    end
    r = x;
  endfunction

  task automatic check(input bit ok, input string tag,
      input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample at the next negedge (one register stage)
  task automatic run(input logic [2:0] o, input logic w64, input logic [63:0] s,
      input logic [7:0] a, input logic ci, input string tag);
    logic [63:0] er;
    logic ec, ez, es;
    model(o, w64, s, a, ci, er, ec);
    ez = (er == '0);
    es = w64 ? er[63] : er[31];
    op = o; wide = w64; src = s; amount = a; carry_in = ci; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && result == er && flag_c == ec && flag_z == ez && flag_s == es,
          tag, {out_valid, flag_c, flag_z, flag_s, result},
          {1'b1, ec, ez, es, er});
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2";
      3'd1, 3'd2: return "R3";
      3'd3, 3'd4: return "R4";
      3'd5, 3'd6: return "R5";
      default: return "R10";
    endcase
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [63:0] hi, lo, nhi, nlo, keep;
    logic        c1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(out_valid == 0 && result == 0 && flag_c == 0 && flag_z == 0 && flag_s == 0,
          "R9 reset", {out_valid, flag_c, flag_z, flag_s, result}, '0);

    run(3'd0, 1'b1, 64'h8000_0000_0000_0001, 8'd1, 1'b0, "R2 shl wide");
    run(3'd0, 1'b0, 64'hFFFF_0000_8000_0001, 8'd4, 1'b0, "R2 shl narrow");
    run(3'd1, 1'b1, 64'h8000_0000_0000_0003, 8'd2, 1'b0, "R3 shr");
    run(3'd2, 1'b1, 64'h8000_0000_0000_0000, 8'd63, 1'b0, "R3 sar by W-1");
    run(3'd2, 1'b0, 64'h0000_0000_8000_0000, 8'd31, 1'b0, "R3 sar narrow by W-1");
    run(3'd3, 1'b1, 64'h8000_0000_0000_0000, 8'd1, 1'b0, "R4 rol");
    run(3'd4, 1'b0, 64'h0000_0000_0000_0001, 8'd1, 1'b0, "R4 ror narrow");
    run(3'd5, 1'b1, 64'h8000_0000_0000_0000, 8'd1, 1'b1, "R5 rolc");
    run(3'd6, 1'b0, 64'h0000_0000_0000_0001, 8'd3, 1'b1, "R5 rorc narrow");
    run(3'd0, 1'b1, 64'h1234_5678_9ABC_DEF0, 8'd64, 1'b1, "R6 R1 count 64 masks to zero");
    run(3'd5, 1'b0, 64'h0000_0000_8765_4321, 8'd32, 1'b1, "R6 R1 count 32 narrow");
    run(3'd1, 1'b1, 64'h0000_0000_0000_0003, 8'h41, 1'b0, "R1 amount 0x41 wide");
    run(3'd1, 1'b0, 64'h0000_0000_0000_0003, 8'h21, 1'b0, "R1 amount 0x21 narrow");
    run(3'd0, 1'b0, 64'h0000_0000_8000_0000, 8'd1, 1'b0, "R7 zero result");
    run(3'd4, 1'b1, 64'h0000_0000_0000_0001, 8'd1, 1'b0, "R7 sign set");
    run(3'd3, 1'b0, 64'hFFFF_FFFF_0000_0001, 8'd5, 1'b0, "R8 narrow ignores upper");
    run(3'd7, 1'b1, 64'hCAFE_F00D_0000_1234, 8'd9, 1'b1, "R10 pass");

    // R9 hold: idle cycle keeps previous result, no valid
    keep = result;
    @(negedge clk);
    check(!out_valid && result == keep, "R9 idle hold",
          {out_valid, 3'b0, result}, {1'b0, 3'b0, keep});

    // R5 128-bit rotate left by one from two chained steps
    for (int k = 0; k < 8; k++) begin
      hi = {$urandom, $urandom};
      lo = {$urandom, $urandom};
      run(3'd5, 1'b1, lo, 8'd1, hi[63], "R5 chain low");
      nlo = result; c1 = flag_c;
      run(3'd5, 1'b1, hi, 8'd1, c1, "R5 chain high");
      nhi = result;
      check({nhi, nlo} == {hi[62:0], lo, hi[63]}, "R5 128-bit rotate",
            68'({nhi[3:0], nlo}), 68'({hi[2:0], lo[63], lo[62:0], hi[63]}));
    end

    // random sweep, model compared on every request
    for (int k = 0; k < 400; k++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      run(ro, 1'($urandom), {$urandom, $urandom}, 8'($urandom), 1'($urandom), tag_of(ro));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule